// File: doc/BRIEF.md
# Dual-Stack Forth Processor Core

This block is a 16-bit stack machine built for Forth-style code. It keeps the top of the data stack in a register and holds the rest of that stack, and a separate return stack, in small internal memories. Instructions are 16 bits wide. They come from an external single-ported memory with one cycle of read latency. Loads, stores and I/O transfers use that same port (or a separate I/O port), so each of them costs one extra cycle.

An instruction with the top bit set pushes a constant. The other three opcodes of the 3-bit class field are jump, branch-if-zero and call. The remaining class is a horizontally coded ALU word. Its bit fields pick the next top-of-stack value, move T into the stack memories, write memory, steer the access to I/O space, return through the return stack, and adjust each stack pointer by a signed 2-bit step. A return costs nothing when it is folded into an ALU word.

Top module: `forth_stack_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the program counter, T and both stack pointers are zero. The core fetches from byte address 0 and asserts no write or I/O strobe.
- R2: When bit 15 is 1, bits 14..0 are zero-extended and pushed, and the data pointer grows by one.
- R3: Class 000 (bits 15..13) loads bits 12..0, zero-extended, into the PC. The fetch byte address is twice that value.
- R4: Class 001 pops T. It branches to the 13-bit target only when the popped value is zero; otherwise it goes on to PC+1.
- R5: Class 010 pushes the byte address of the following instruction onto the return stack and jumps, all in one cycle. An ALU word with bit 12 set takes its next PC from return-stack word bits 15..1.
- R6: In an ALU word (class 011), bits 11..8 select the new T: 0 T, 1 N, 2 T+N, 3 AND, 4 OR, 5 XOR, 6 NOT T, 7 N==T, 8 signed N<T, 9 N>>(T mod 16), 10 N−T, 11 R, 13 N<<(T mod 16), 15 unsigned N<T. Comparisons give all ones or all zeros.
- R7: Select 14 returns the return pointer in bits 15..8 and the data pointer in bits 7..0, as they stood when the word began.
- R8: Bits 1..0 and 3..2 are two's-complement steps for the data and return pointers, applied after the stack reads. Bit 7 writes T, and bit 6 writes T to the return stack, at the adjusted slot.
- R9: Bit 5 writes N to memory at T with bit 0 cleared. The write cycle is followed by one refetch cycle with no strobe.
- R10: Select 12 presents T as the read address. T takes the returned word in the second cycle.
- R11: With bit 4 set, the load or store uses the I/O port at address T instead, and the memory write strobe stays low.
- R12: An access instruction takes two cycles. All others take one. PC and stack pointers advance only once per instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Byte address for fetch, load or store |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Store data (N) |
| mem_rdata | input | 16 | Read word, one cycle after its address |
| io_addr | output | 16 | I/O address (T) |
| io_we | output | 1 | I/O write strobe |
| io_re | output | 1 | I/O read strobe; data is expected the next cycle |
| io_wdata | output | 16 | I/O write data (N) |
| io_rdata | input | 16 | I/O read word |

## Verification
Cycle 0 is the first cycle after reset, and it is a fetch cycle. Every ordinary instruction then executes one cycle after its own fetch. Each load or store inserts one more cycle, so the cycle of any I/O write can be predicted by counting. The bench checks the cycles of the first three I/O writes against that count (3, 7 and 12). A store's address and data are captured in its own cycle. The result of a load is observed only after it has gone back out through a later I/O write. All bus outputs are sampled at the falling edge, after the registers have settled.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int WORD_W = 16;
  localparam int TGT_W  = 13;

  typedef enum logic [3:0] {
    SEL_T, SEL_N, SEL_ADD, SEL_AND, SEL_OR, SEL_XOR, SEL_INV, SEL_EQ,
    SEL_SLT, SEL_SHR, SEL_SUB, SEL_R, SEL_LOAD, SEL_SHL, SEL_DEPTH, SEL_ULT
  } tsel_e;

  typedef enum logic [1:0] {K_JMP, K_CBR, K_CALL, K_ALU} kind_e;

  typedef enum logic [1:0] {PH_FETCH, PH_EXEC, PH_LOAD} phase_e;

  typedef struct packed {
    logic             is_lit;
    kind_e            kind;
    logic             ret;
    tsel_e            tsel;
    logic             t2n;
    logic             t2r;
    logic             store;
    logic             io;
    logic [1:0]       radj;
    logic [1:0]       dadj;
    logic [TGT_W-1:0] target;
    logic [14:0]      lit;
  } insn_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [WORD_W-1:0] ir,
  output insn_t             dec
);
  always_comb begin
    dec        = '0;
    dec.is_lit = ir[15];
    dec.kind   = kind_e'(ir[14:13]);
    dec.target = ir[TGT_W-1:0];
    dec.lit    = ir[14:0];
    // ALU control fields only carry meaning in class 011
    if (!ir[15] && ir[14:13] == 2'b11) begin
      dec.ret   = ir[12];
      dec.tsel  = tsel_e'(ir[11:8]);
      dec.t2n   = ir[7];
      dec.t2r   = ir[6];
      dec.store = ir[5];
      dec.io    = ir[4];
      dec.radj  = ir[3:2];
      dec.dadj  = ir[1:0];
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  tsel_e        sel,
  input  logic [W-1:0] t,
  input  logic [W-1:0] n,
  input  logic [W-1:0] r,
  input  logic [W-1:0] depth,
  output logic [W-1:0] y
);
  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] sh;
  assign sh = t[SH_W-1:0];

  always_comb begin
    case (sel)
      SEL_T:     y = t;
      SEL_N:     y = n;
      SEL_ADD:   y = t + n;
      SEL_AND:   y = t & n;
      SEL_OR:    y = t | n;
      SEL_XOR:   y = t ^ n;
      SEL_INV:   y = ~t;
      SEL_EQ:    y = {W{n == t}};
      SEL_SLT:   y = {W{$signed(n) < $signed(t)}};
      SEL_SHR:   y = n >> sh;
      SEL_SUB:   y = n - t;
      SEL_R:     y = r;
      SEL_LOAD:  y = t;   // T is the address; result arrives next cycle
      SEL_SHL:   y = n << sh;
      SEL_DEPTH: y = depth;
      SEL_ULT:   y = {W{n < t}};
    endcase
  end
endmodule

// File: rtl/sc_stack.sv
module sc_stack #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [1:0]    adj,
  input  logic          push_we,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] top,
  output logic [AW-1:0] ptr
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_nx;

  assign ptr_nx = ptr_q + {{(AW-2){adj[1]}}, adj};

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (step) ptr_q <= ptr_nx;
  end

  // write lands on the slot after adjustment, no reset on storage
  always_ff @(posedge clk) begin
    if (step && push_we) cells[ptr_nx] <= push_data;
  end

  assign top = cells[ptr_q];
  assign ptr = ptr_q;
endmodule

// File: rtl/forth_stack_core.sv
module forth_stack_core
  import sc_pkg::*;
#(
  parameter int DSTK_AW = 8,
  parameter int RSTK_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] io_addr,
  output logic              io_we,
  output logic              io_re,
  output logic [WORD_W-1:0] io_wdata,
  input  logic [WORD_W-1:0] io_rdata
);
  localparam int PC_W    = WORD_W - 1;
  localparam int FIELD_W = WORD_W / 2;

  phase_e            phase_q;
  logic [PC_W-1:0]   pc_q;
  logic [WORD_W-1:0] t_q;
  logic              load_io_q;

  insn_t             dec;
  logic              exec;
  logic              is_alu;
  logic [PC_W-1:0]   pc_inc;
  logic [PC_W-1:0]   pc_nx;
  logic [WORD_W-1:0] t_nx;
  logic [1:0]        d_adj;
  logic [1:0]        r_adj;
  logic              d_we;
  logic              r_we;
  logic [WORD_W-1:0] r_wdata;
  logic              is_load;
  logic              access;

  logic [WORD_W-1:0] n_bus;
  logic [WORD_W-1:0] r_bus;
  logic [DSTK_AW-1:0] dsp;
  logic [RSTK_AW-1:0] rsp;
  logic [WORD_W-1:0] depth_word;
  logic [WORD_W-1:0] alu_y;
  logic              unused_rbit;

  sc_decode u_dec (.ir(mem_rdata), .dec(dec));

  assign exec       = (phase_q == PH_EXEC);
  assign is_alu     = !dec.is_lit && dec.kind == K_ALU;
  assign pc_inc     = pc_q + 1'b1;
  assign depth_word = {FIELD_W'(rsp), FIELD_W'(dsp)};
  assign unused_rbit = r_bus[0];

  sc_alu #(.W(WORD_W)) u_alu (
    .sel(dec.tsel), .t(t_q), .n(n_bus), .r(r_bus), .depth(depth_word), .y(alu_y)
  );

  sc_stack #(.AW(DSTK_AW), .DW(WORD_W)) u_dstk (
    .clk(clk), .rst(rst), .step(exec), .adj(d_adj), .push_we(d_we),
    .push_data(t_q), .top(n_bus), .ptr(dsp)
  );

  sc_stack #(.AW(RSTK_AW), .DW(WORD_W)) u_rstk (
    .clk(clk), .rst(rst), .step(exec), .adj(r_adj), .push_we(r_we),
    .push_data(r_wdata), .top(r_bus), .ptr(rsp)
  );

  // instruction effects, valid while exec
  always_comb begin
    pc_nx   = pc_inc;
    t_nx    = t_q;
    d_adj   = 2'b00;
    r_adj   = 2'b00;
    d_we    = 1'b0;
    r_we    = 1'b0;
    r_wdata = t_q;
    is_load = 1'b0;
    access  = 1'b0;
    if (dec.is_lit) begin
      d_adj = 2'b01;
      d_we  = 1'b1;
      t_nx  = {1'b0, dec.lit};
    end else begin
      case (dec.kind)
        K_JMP: pc_nx = PC_W'(dec.target);
        K_CBR: begin
          d_adj = 2'b11;
          t_nx  = n_bus;
          if (t_q == '0) pc_nx = PC_W'(dec.target);
        end
        K_CALL: begin
          r_adj   = 2'b01;
          r_we    = 1'b1;
          r_wdata = {pc_inc, 1'b0};
          pc_nx   = PC_W'(dec.target);
        end
        K_ALU: begin
          t_nx    = alu_y;
          d_adj   = dec.dadj;
          r_adj   = dec.radj;
          d_we    = dec.t2n;
          r_we    = dec.t2r;
          if (dec.ret) pc_nx = r_bus[WORD_W-1:1];
          is_load = (dec.tsel == SEL_LOAD);
          access  = is_load || dec.store;
        end
      endcase
    end
  end

  // port steering: one memory address per cycle
  always_comb begin
    if (exec && access && !dec.io) mem_addr = {t_q[WORD_W-1:1], 1'b0};
    else if (exec && !access)      mem_addr = {pc_nx, 1'b0};
    else                           mem_addr = {pc_q, 1'b0};
  end

  assign mem_we    = exec && is_alu && dec.store && !dec.io;
  assign mem_wdata = n_bus;
  assign io_addr   = t_q;
  assign io_we     = exec && is_alu && dec.store && dec.io;
  assign io_re     = exec && is_load && dec.io;
  assign io_wdata  = n_bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_FETCH;
      pc_q      <= '0;
      t_q       <= '0;
      load_io_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_FETCH: phase_q <= PH_EXEC;
        PH_LOAD: begin
          t_q     <= load_io_q ? io_rdata : mem_rdata;
          phase_q <= PH_EXEC;
        end
        default: begin
          pc_q <= pc_nx;
          t_q  <= t_nx;
          if (access) begin
            phase_q   <= is_load ? PH_LOAD : PH_FETCH;
            load_io_q <= dec.io;
          end
        end
      endcase
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_q == '0 && t_q == '0 && dsp == '0 && rsp == '0 && mem_addr == '0)); // R1

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !exec |=> ($stable(pc_q) && $stable(dsp) && $stable(rsp))); // R12

  AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (!mem_we && !io_we)); // R9

  AST_IO_READ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    io_re |=> (!io_re && !mem_we)); // R11

  AST_CMP_MASK: assert property (@(posedge clk) disable iff (rst)
    (exec && is_alu && (dec.tsel == SEL_EQ || dec.tsel == SEL_SLT || dec.tsel == SEL_ULT))
      |-> (alu_y == '0 || alu_y == '1)); // R6
endmodule

// File: tb/forth_stack_core_bench.sv
`timescale 1ns/1ps
module forth_stack_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [15:0] mem_addr, mem_wdata, io_addr, io_wdata;
  logic [15:0] mem_rdata = '0;
  logic [15:0] io_rdata = '0;
  logic        mem_we, io_we, io_re;

  forth_stack_core u_forth_stack_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .io_addr(io_addr), .io_we(io_we), .io_re(io_re),
    .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  logic [15:0] ram [0:4095];
  int tests = 0;
  int fails = 0;
  int cyc_n = 0;
  int pa = 0;

  logic [15:0] s_maddr = '0, s_mwd = '0, s_ioaddr = '0;
  logic        s_mwe = 1'b0, s_iore = 1'b0;

  logic [15:0] lg_addr [0:127];
  logic [15:0] lg_data [0:127];
  int          lg_cyc  [0:127];
  int          lg_n = 0;
  logic [15:0] st_addr [0:15];
  logic [15:0] st_data [0:15];
  int          st_n = 0;
  logic [15:0] exp_port [0:63];
  logic [15:0] exp_val  [0:63];

  function automatic logic [15:0] io_fn(input logic [15:0] a);
    return a ^ 16'hC3A5;
  endfunction

  // bus sampling away from the active edge
  always @(negedge clk) begin
    s_maddr = mem_addr; s_mwe = mem_we; s_mwd = mem_wdata;
    s_ioaddr = io_addr; s_iore = io_re;
    if (rst) cyc_n = 0;
    else begin
      if (io_we && lg_n < 128) begin
        lg_addr[lg_n] = io_addr; lg_data[lg_n] = io_wdata; lg_cyc[lg_n] = cyc_n; lg_n++;
      end
      if (mem_we && st_n < 16) begin
        st_addr[st_n] = mem_addr; st_data[st_n] = mem_wdata; st_n++;
      end
      cyc_n++;
    end
  end

  // single-ported synchronous memory and registered I/O read
  always @(posedge clk) begin
    mem_rdata <= ram[s_maddr[12:1]];
    if (s_mwe) ram[s_maddr[12:1]] <= s_mwd;
    if (s_iore) io_rdata <= io_fn(s_ioaddr);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] e_lit(input logic [14:0] v); return {1'b1, v}; endfunction
  function automatic logic [15:0] e_jmp(input logic [12:0] t); return {3'b000, t}; endfunction
  function automatic logic [15:0] e_cbr(input logic [12:0] t); return {3'b001, t}; endfunction
  function automatic logic [15:0] e_call(input logic [12:0] t); return {3'b010, t}; endfunction
  function automatic logic [15:0] e_alu(input logic ret, input logic [3:0] sel, input logic tn,
      input logic tr, input logic nm, input logic io, input logic [1:0] radj, input logic [1:0] dadj);
    return {3'b011, ret, sel, tn, tr, nm, io, radj, dadj};
  endfunction

  function automatic logic [15:0] ref_op(input logic [3:0] sel, input logic [15:0] t, input logic [15:0] n);
    case (sel)
      4'd0:  return t;
      4'd1:  return n;
      4'd2:  return t + n;
      4'd3:  return t & n;
      4'd4:  return t | n;
      4'd5:  return t ^ n;
      4'd6:  return ~t;
      4'd7:  return (n == t) ? 16'hFFFF : 16'h0000;
      4'd8:  return ($signed(n) < $signed(t)) ? 16'hFFFF : 16'h0000;
      4'd9:  return n >> t[3:0];
      4'd10: return n - t;
      4'd13: return n << t[3:0];
      4'd15: return (n < t) ? 16'hFFFF : 16'h0000;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic put(input logic [15:0] w); ram[pa] = w; pa++; endtask
  task automatic at(input int a); pa = a; endtask
  // push port, write N to it through I/O, T takes the value back
  task automatic emit(input logic [14:0] port);
    put(e_lit(port));
    put(e_alu(1'b0, 4'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b11));
  endtask

  task automatic clear_all();
    rst = 1'b1;
    for (int i = 0; i < 4096; i++) ram[i] = 16'h0000;
    lg_n = 0; st_n = 0; pa = 0;
  endtask

  task automatic release_and_check_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk("R1 fetch address", mem_addr, 16'h0000);
    chk("R1 strobes", {mem_we, io_we, io_re}, 3'b000);
  endtask

  task automatic wait_log(input int want, input int limit, input string req);
    int k = 0;
    while (lg_n < want && k < limit) begin @(negedge clk); #1; k++; end
    if (lg_n < want) begin
      tests++; fails++;
      $display("FAIL %s watchdog actual=%0d expected=%0d writes", req, lg_n, want);
    end
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] dp [0:8];
    logic [15:0] dv [0:8];
    void'($urandom(32'd20240611));

    // ---------------- directed program ----------------
    clear_all();
    at(0);
    put(e_lit(15'h7FFF)); emit(1);                                    // 0..2
    put(e_alu(0, 4'd14, 0, 0, 0, 0, 2'b00, 2'b00)); emit(2);          // 3..5
    put(e_call(13'd40));                                              // 6
    emit(4);                                                          // 7..8
    put(e_lit(15'h5A5A)); put(e_lit(15'h0203));                       // 9..10
    put(e_alu(0, 4'd1, 0, 0, 1, 0, 2'b00, 2'b11));                    // 11 store
    put(e_lit(15'h0202)); put(e_alu(0, 4'd12, 0, 0, 0, 0, 2'b00, 2'b00)); // 12..13 load
    emit(5);                                                          // 14..15
    put(e_lit(15'h0)); put(e_cbr(13'd20));                            // 16..17
    put(e_jmp(13'd50)); put(e_jmp(13'd50));                           // 18..19
    put(e_lit(15'h3)); put(e_cbr(13'd50));                            // 20..21
    put(e_lit(15'h0ABC)); emit(6);                                    // 22..24
    put(e_lit(15'h0050)); put(e_alu(0, 4'd12, 0, 0, 0, 1, 2'b00, 2'b00)); // 25..26 io load
    emit(7);                                                          // 27..28
    put(e_alu(0, 4'd14, 0, 0, 0, 0, 2'b00, 2'b00)); emit(9);          // 29..31
    put(e_jmp(13'd32));                                               // 32
    at(40);
    put(e_alu(0, 4'd11, 1, 0, 0, 0, 2'b00, 2'b01));                   // 40 copy R
    emit(3);                                                          // 41..42
    put(e_alu(0, 4'd14, 0, 0, 0, 0, 2'b00, 2'b00)); emit(8);          // 43..45
    put(e_alu(1, 4'd1, 0, 0, 0, 0, 2'b11, 2'b11));                    // 46 drop+return
    at(50);
    put(e_lit(15'h0BAD)); emit(15); put(e_jmp(13'd53));               // 50..53

    dp = '{16'd1, 16'd2, 16'd3, 16'd8, 16'd4, 16'd5, 16'd6, 16'd7, 16'd9};
    dv = '{16'h7FFF, 16'h0001, 16'h000E, 16'h0102, 16'h0001, 16'h5A5A, 16'h0ABC, 16'hC3F5, 16'h0005};

    release_and_check_reset();
    wait_log(9, 400, "R12 directed run");
    repeat (20) @(negedge clk);
    #1;
    chk("R4 no untaken-path write", lg_n, 9);
    for (int i = 0; i < 9; i++) begin
      case (i)
        0: chk("R2 literal port", lg_addr[i], dp[i]);
        1: chk("R7 depth port", lg_addr[i], dp[i]);
        2: chk("R5 call port", lg_addr[i], dp[i]);
        4: chk("R5 return port", lg_addr[i], dp[i]);
        5: chk("R10 load port", lg_addr[i], dp[i]);
        6: chk("R4 branch port", lg_addr[i], dp[i]);
        7: chk("R11 io port", lg_addr[i], dp[i]);
        default: chk("R11 port order", lg_addr[i], dp[i]);
      endcase
    end
    chk("R2 literal zero-extended", lg_data[0], dv[0]);
    chk("R7 depth before call", lg_data[1], dv[1]);
    chk("R5 return byte address", lg_data[2], dv[2]);
    chk("R7 depth inside call", lg_data[3], dv[3]);
    chk("R8 drop with return", lg_data[4], dv[4]);
    chk("R10 load result", lg_data[5], dv[5]);
    chk("R4 branch results", lg_data[6], dv[6]);
    chk("R11 io load result", lg_data[7], dv[7]);
    chk("R8 final depth", lg_data[8], dv[8]);
    chk("R12 first io write cycle", lg_cyc[0], 3);
    chk("R12 second io write cycle", lg_cyc[1], 7);
    chk("R5 call single cycle", lg_cyc[2], 12);
    chk("R9 one memory store", st_n, 1);
    chk("R9 store address bit0 dropped", st_addr[0], 16'h0202);
    chk("R9 store data", st_data[0], 16'h5A5A);
    chk("R9 memory contents", ram[12'h101], 16'h5A5A);
    chk("R3 jump fetch address", mem_addr, 16'h0040);
    chk("R11 memory strobe idle", mem_we, 1'b0);

    // ---------------- random ALU program ----------------
    clear_all();
    at(0);
    for (int i = 0; i < 60; i++) begin
      logic [14:0] a, b;
      logic        ia, ib;
      logic [3:0]  sel;
      logic [15:0] av, bv;
      int unsigned k;
      a = 15'($urandom); b = 15'($urandom);
      ia = 1'($urandom); ib = 1'($urandom);
      k = $urandom_range(12);
      case (k)
        11: sel = 4'd13;
        12: sel = 4'd15;
        default: sel = 4'(k);
      endcase
      if (i == 0) begin a = 15'h1234; b = 15'h0013; ia = 0; ib = 0; sel = 4'd13; end
      if (i == 1) begin a = 15'h0005; b = 15'h0005; ia = 1; ib = 1; sel = 4'd7; end
      av = ia ? ~{1'b0, a} : {1'b0, a};
      bv = ib ? ~{1'b0, b} : {1'b0, b};
      put(e_lit(a)); if (ia) put(e_alu(0, 4'd6, 0, 0, 0, 0, 2'b00, 2'b00));
      put(e_lit(b)); if (ib) put(e_alu(0, 4'd6, 0, 0, 0, 0, 2'b00, 2'b00));
      if (sel == 4'd0 || sel == 4'd6) begin
        put(e_alu(0, sel, 0, 0, 0, 0, 2'b00, 2'b00));
        emit(15'(i + 16));
        put(e_alu(0, 4'd0, 0, 0, 0, 0, 2'b00, 2'b11));
        put(e_alu(0, 4'd0, 0, 0, 0, 0, 2'b00, 2'b11));
      end else begin
        put(e_alu(0, sel, 0, 0, 0, 0, 2'b00, 2'b11));
        emit(15'(i + 16));
        put(e_alu(0, 4'd0, 0, 0, 0, 0, 2'b00, 2'b11));
      end
      exp_port[i] = 16'(i + 16);
      exp_val[i]  = ref_op(sel, bv, av);
    end
    put(e_jmp(13'(pa)));

    release_and_check_reset();
    wait_log(60, 4000, "R6 random run");
    for (int i = 0; i < 60 && i < lg_n; i++) begin
      chk("R6 alu port", lg_addr[i], exp_port[i]);
      chk("R6 alu result", lg_data[i], exp_val[i]);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule